// File: doc/BRIEF.md
# SDRAM Request Page Splitter

This block sits between an application request port and a downstream SDRAM bank controller. An upstream request carries a linear word address, a transfer count and a read/write flag, plus a per-request wrap flag. The block slices the address into column, bank and row fields. Where each field sits depends on a run-time column-width setting, so the bank and row fields move up as the column widens.

When wrap is off, a request that would run past the end of an SDRAM page is cut into page-bounded sub-requests. Each sub-request is handed downstream through a request/acknowledge handshake, one after another. The first sub-request covers what fits between the starting column and the page end. Each later one starts at column 0 of the next page and covers at most one full page.

When wrap is on, the request goes downstream unchanged as one sub-request, and the bank controller wraps its column within the page. The upstream side is acknowledged only once the last sub-request has been taken downstream.

Top module: `rsplit_top`

## Requirements
- R1: With column setting 0 (cfg_col_sel = 2'b00) the column is address bits 7:0, the bank is bits 9:8 and the row is bits 21:10.
- R2: With column setting 1 the column is bits 8:0, the bank is bits 10:9 and the row is bits 22:11.
- R3: With column setting 2 the column is bits 9:0, the bank is bits 11:10 and the row is bits 23:12.
- R4: With column setting 3 the column is bits 10:0, the bank is bits 12:11 and the row is bits 24:13. The bank is always 2 bits and the row always 12 bits.
- R5: With wrap off, the first sub-request covers the smaller of the requested transfer count and (page size minus starting column), where the page size is 2^(8+cfg_col_sel). No sub-request runs past the end of its page.
- R6: Each later sub-request starts at column 0 of the next page, with a transfer count equal to the smaller of the remaining count and one page. The next page is the 14-bit value {row, bank} plus one, modulo 2^14, so the bank advances first and carries into the row.
- R7: Length fields, upstream and downstream, hold the transfer count minus one, so 0 means one transfer.
- R8: up_ack_o is a single-cycle pulse. It rises on the cycle after the last sub-request handshake, and never while dn_req_o is high. A sub-request sequence starts only from an upstream request.
- R9: While a split is in progress, changes on the upstream address, length, direction and wrap inputs have no effect on the sub-requests emitted.
- R10: With wrap on, exactly one sub-request is emitted, carrying the original column and length, with dn_wrap_o high.
- R11: After reset, dn_req_o and up_ack_o are low.
- R12: While dn_req_o is high and dn_ack_i is low, dn_req_o stays high and every downstream field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_col_sel | input | 2 | Column width select: 8 + value bits |
| up_req_i | input | 1 | Upstream request, held until up_ack_o |
| up_addr_i | input | ADDR_W | Linear word address |
| up_len_i | input | LEN_W | Transfer count minus one |
| up_wr_i | input | 1 | 1 = write, 0 = read |
| up_wrap_i | input | 1 | 1 = forward unsplit with column wrap |
| up_ack_o | output | 1 | Upstream acknowledge pulse |
| dn_req_o | output | 1 | Sub-request valid |
| dn_row_o | output | 12 | Sub-request row |
| dn_bank_o | output | 2 | Sub-request bank |
| dn_col_o | output | 11 | Sub-request starting column |
| dn_len_o | output | LEN_W | Sub-request transfer count minus one |
| dn_wr_o | output | 1 | Sub-request direction |
| dn_wrap_o | output | 1 | Sub-request wrap flag |
| dn_ack_i | input | 1 | Bank controller accepts the sub-request |

## Verification
The bench builds the block with its defaults, ADDR_W = 26 and LEN_W = 9. A 26-bit address reaches the top row bit under the widest column setting, so page-index rollover from the all-ones row and bank back to zero can be driven. A 9-bit length allows 512 transfers, which splits into three pieces at the smallest 256-word page, with a full-page middle piece. The downstream acknowledge is stalled for varying numbers of cycles, so field hold and back-to-back handoffs are both seen.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;
    localparam int ROW_W     = 12;
    localparam int BANK_W    = 2;
    localparam int PAGE_W    = ROW_W + BANK_W;
    localparam int COL_BASE  = 8;
    localparam int N_COLSEL  = 4;
    localparam int COL_MAX   = COL_BASE + N_COLSEL - 1;
    localparam int SEL_W     = $clog2(N_COLSEL);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } split_st_e;
endpackage

// File: rtl/rsplit_decode.sv
module rsplit_decode
    import rsplit_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [COL_MAX-1:0] col_o,
    output logic [PAGE_W-1:0]  page_o
);
    logic [COL_MAX-1:0] col_v  [N_COLSEL];
    logic [PAGE_W-1:0]  page_v [N_COLSEL];

    // One slicing variant per column width; the page index is {row, bank}.
    for (genvar g = 0; g < N_COLSEL; g++) begin : g_var
        localparam int CW = COL_BASE + g;
        assign col_v[g]  = COL_MAX'(addr_i[CW-1:0]);
        assign page_v[g] = addr_i[CW+PAGE_W-1:CW];
    end

    assign col_o  = col_v[sel_i];
    assign page_o = page_v[sel_i];
endmodule

// File: rtl/rsplit_chunk.sv
module rsplit_chunk
    import rsplit_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic [LEN_W:0]     rem_i,
    input  logic [COL_MAX-1:0] col_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               wrap_i,
    output logic [LEN_W:0]     sub_o,
    output logic               last_o
);
    localparam int CNT_W  = LEN_W + 1;
    localparam int PSZ_W  = COL_MAX + 1;
    localparam int CALC_W = (CNT_W > PSZ_W) ? CNT_W : PSZ_W;

    logic [PSZ_W-1:0]  psize;
    logic [PSZ_W-1:0]  room;
    logic [CALC_W-1:0] room_c;
    logic [CALC_W-1:0] rem_c;
    logic [CALC_W-1:0] sub_c;

    always_comb begin
        psize  = PSZ_W'(1) << (COL_BASE + int'(sel_i));
        room   = psize - {1'b0, col_i};
        room_c = CALC_W'(room);
        rem_c  = CALC_W'(rem_i);
        sub_c  = (wrap_i || (rem_c <= room_c)) ? rem_c : room_c;
        sub_o  = CNT_W'(sub_c);
        last_o = (sub_o == rem_i);
    end
endmodule

// File: rtl/rsplit_top.sv
module rsplit_top
    import rsplit_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int LEN_W  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   cfg_col_sel,
    input  logic               up_req_i,
    input  logic [ADDR_W-1:0]  up_addr_i,
    input  logic [LEN_W-1:0]   up_len_i,
    input  logic               up_wr_i,
    input  logic               up_wrap_i,
    output logic               up_ack_o,
    output logic               dn_req_o,
    output logic [ROW_W-1:0]   dn_row_o,
    output logic [BANK_W-1:0]  dn_bank_o,
    output logic [COL_MAX-1:0] dn_col_o,
    output logic [LEN_W-1:0]   dn_len_o,
    output logic               dn_wr_o,
    output logic               dn_wrap_o,
    input  logic               dn_ack_i
);
    localparam int CNT_W = LEN_W + 1;

    typedef struct packed {
        split_st_e          st;
        logic [SEL_W-1:0]   sel;
        logic [COL_MAX-1:0] col;
        logic [PAGE_W-1:0]  page;
        logic [CNT_W-1:0]   rem;
        logic               wr;
        logic               wrap;
    } split_regs_t;

    split_regs_t r_q, r_d;

    logic [COL_MAX-1:0] dec_col;
    logic [PAGE_W-1:0]  dec_page;
    logic [CNT_W-1:0]   sub_cnt;
    logic               sub_last;

    rsplit_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (up_addr_i),
        .sel_i  (cfg_col_sel),
        .col_o  (dec_col),
        .page_o (dec_page)
    );

    rsplit_chunk #(.LEN_W(LEN_W)) u_chunk (
        .rem_i  (r_q.rem),
        .col_i  (r_q.col),
        .sel_i  (r_q.sel),
        .wrap_i (r_q.wrap),
        .sub_o  (sub_cnt),
        .last_o (sub_last)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (up_req_i) begin
                    r_d.st   = ST_ISSUE;
                    r_d.sel  = cfg_col_sel;
                    r_d.col  = dec_col;
                    r_d.page = dec_page;
                    r_d.rem  = CNT_W'(up_len_i) + CNT_W'(1);
                    r_d.wr   = up_wr_i;
                    r_d.wrap = up_wrap_i;
                end
            end
            ST_ISSUE: begin
                if (dn_ack_i) begin
                    if (sub_last) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.col  = '0;
                        r_d.page = r_q.page + PAGE_W'(1);
                        r_d.rem  = r_q.rem - sub_cnt;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign up_ack_o  = (r_q.st == ST_DONE);
    assign dn_req_o  = (r_q.st == ST_ISSUE);
    assign dn_col_o  = r_q.col;
    assign dn_bank_o = r_q.page[BANK_W-1:0];
    assign dn_row_o  = r_q.page[PAGE_W-1:BANK_W];
    assign dn_len_o  = LEN_W'(sub_cnt - CNT_W'(1));
    assign dn_wr_o   = r_q.wr;
    assign dn_wrap_o = r_q.wrap;
endmodule

// File: rtl/rsplit_chk.sv
module rsplit_chk
    import rsplit_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SEL_W-1:0]   cfg_col_sel,
    input logic               up_req_i,
    input logic               up_ack_o,
    input logic               dn_req_o,
    input logic [ROW_W-1:0]   dn_row_o,
    input logic [BANK_W-1:0]  dn_bank_o,
    input logic [COL_MAX-1:0] dn_col_o,
    input logic [LEN_W-1:0]   dn_len_o,
    input logic               dn_wr_o,
    input logic               dn_wrap_o,
    input logic               dn_ack_i
);
    // R12
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_o && !dn_ack_i) |=> (dn_req_o &&
            $stable({dn_row_o, dn_bank_o, dn_col_o, dn_len_o, dn_wr_o, dn_wrap_o})));

    // R8
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack_o |=> !up_ack_o);

    // R8
    ack_not_with_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack_o |-> !dn_req_o);

    // R8
    start_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req_o) |-> $past(up_req_i));

    // R5
    within_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_o && !dn_wrap_o) |->
            ((int'(dn_col_o) + int'(dn_len_o) + 1) <= (1 << (COL_BASE + int'(cfg_col_sel)))));

    // R10
    wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_o && dn_ack_i && dn_wrap_o) |=> up_ack_o);
endmodule

bind rsplit_top rsplit_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_col_sel (cfg_col_sel),
    .up_req_i    (up_req_i),
    .up_ack_o    (up_ack_o),
    .dn_req_o    (dn_req_o),
    .dn_row_o    (dn_row_o),
    .dn_bank_o   (dn_bank_o),
    .dn_col_o    (dn_col_o),
    .dn_len_o    (dn_len_o),
    .dn_wr_o     (dn_wr_o),
    .dn_wrap_o   (dn_wrap_o),
    .dn_ack_i    (dn_ack_i)
);

// File: tb/rsplit_top_tb_top.sv
module rsplit_top_tb_top;
    localparam int ADDR_W = 26;
    localparam int LEN_W  = 9;
    localparam int ITEM_W = 12 + 2 + 11 + LEN_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_col_sel = '0;
    logic              up_req_i = 1'b0;
    logic [ADDR_W-1:0] up_addr_i = '0;
    logic [LEN_W-1:0]  up_len_i = '0;
    logic              up_wr_i = 1'b0;
    logic              up_wrap_i = 1'b0;
    logic              up_ack_o;
    logic              dn_req_o;
    logic [11:0]       dn_row_o;
    logic [1:0]        dn_bank_o;
    logic [10:0]       dn_col_o;
    logic [LEN_W-1:0]  dn_len_o;
    logic              dn_wr_o;
    logic              dn_wrap_o;
    logic              dn_ack_i = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [ITEM_W-1:0] exp_q[$];
    string             tag_q[$];

    always #10 clk = ~clk;

    rsplit_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk, .rst_n, .cfg_col_sel, .up_req_i, .up_addr_i, .up_len_i,
        .up_wr_i, .up_wrap_i, .up_ack_o, .dn_req_o, .dn_row_o, .dn_bank_o,
        .dn_col_o, .dn_len_o, .dn_wr_o, .dn_wrap_o, .dn_ack_i
    );

    function automatic logic [ITEM_W-1:0] mk_item(logic [11:0] row, logic [1:0] bank,
            logic [10:0] col, logic [LEN_W-1:0] len, logic wr, logic wrap);
        return {row, bank, col, len, wr, wrap};
    endfunction

    function automatic logic [ITEM_W-1:0] seen_item();
        return {dn_row_o, dn_bank_o, dn_col_o, dn_len_o, dn_wr_o, dn_wrap_o};
    endfunction

    task automatic check(string tag, logic [ITEM_W-1:0] got, logic [ITEM_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor and downstream responder: stall a varying number of cycles, then accept.
    int gap_seq = 0;
    int wait_n  = 0;
    always @(negedge clk) begin
        if (rst_n && dn_req_o) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected sub-request", seen_item(), '0);
                dn_ack_i <= 1'b1;
            end else if (wait_n == 0) begin
                check(tag_q.pop_front(), seen_item(), exp_q.pop_front());
                dn_ack_i <= 1'b1;
                gap_seq++;
                wait_n = gap_seq % 3;
            end else begin
                // R12: fields held while stalled
                check("R12 hold", seen_item(), exp_q[0]);
                dn_ack_i <= 1'b0;
                wait_n--;
            end
        end else begin
            dn_ack_i <= 1'b0;
        end
    end

    task automatic send(string tag, logic [1:0] sel, logic [ADDR_W-1:0] addr,
                        logic [LEN_W-1:0] len, logic wr, logic wrap, bit scramble);
        int cw, col, page, cnt, room, sub, guard;
        cw   = 8 + int'(sel);
        col  = int'(addr) & ((1 << cw) - 1);
        page = (int'(addr) >> cw) & 16'h3FFF;
        cnt  = int'(len) + 1;
        if (wrap) begin
            exp_q.push_back(mk_item(12'(page >> 2), 2'(page), 11'(col), len, wr, 1'b1));
            tag_q.push_back({tag, " R10 unsplit"});
        end else begin
            while (cnt > 0) begin
                room = (1 << cw) - col;
                sub  = (cnt < room) ? cnt : room;
                exp_q.push_back(mk_item(12'(page >> 2), 2'(page), 11'(col),
                                        LEN_W'(sub - 1), wr, 1'b0));
                tag_q.push_back({tag, " R5 R6 R7 piece"});
                cnt  = cnt - sub;
                col  = 0;
                page = (page + 1) & 16'h3FFF;
            end
        end
        @(negedge clk);
        cfg_col_sel = sel;
        up_addr_i   = addr;
        up_len_i    = len;
        up_wr_i     = wr;
        up_wrap_i   = wrap;
        up_req_i    = 1'b1;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
            if (scramble && guard == 1) begin
                // R9: inputs change mid-split
                up_addr_i = ~addr;
                up_len_i  = ~len;
                up_wr_i   = ~wr;
                up_wrap_i = ~wrap;
            end
        end while (!up_ack_o && guard < 3000);
        n_chk++;
        if (!up_ack_o || exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R8 %s: ack=%0b pending=%0d expected ack=1 pending=0",
                     tag, up_ack_o, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
        up_req_i = 1'b0;
        @(negedge clk);
        n_chk++;
        if (up_ack_o !== 1'b0 || dn_req_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 %s pulse: ack=%0b req=%0b expected 0 0", tag, up_ack_o, dn_req_o);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(int sel, int row, int bank, int col);
        int cw = 8 + sel;
        return ADDR_W'((row << (cw + 2)) | (bank << cw) | col);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        n_chk++;
        if (dn_req_o !== 1'b0 || up_ack_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: req=%0b ack=%0b expected 0 0", dn_req_o, up_ack_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        send("R1",  2'd0, mk_addr(0, 12'h123, 2, 8'h10),   9'd3,   1'b1, 1'b0, 0);
        send("R1 cross", 2'd0, mk_addr(0, 12'h055, 1, 8'hFE), 9'd5, 1'b0, 1'b0, 0);
        send("R2",  2'd1, mk_addr(1, 12'h0AB, 1, 9'h1F0),  9'd31,  1'b1, 1'b0, 0);
        send("R3",  2'd2, mk_addr(2, 12'h7FF, 3, 10'h3FF), 9'd2,   1'b0, 1'b0, 0);
        send("R4",  2'd3, mk_addr(3, 12'hFFF, 3, 11'h7FE), 9'd4,   1'b1, 1'b0, 0);
        send("R5",  2'd0, mk_addr(0, 12'h200, 0, 8'h80),   9'd511, 1'b1, 1'b0, 0);
        send("R7",  2'd0, mk_addr(0, 12'h001, 3, 8'hFF),   9'd0,   1'b0, 1'b0, 0);
        send("R10", 2'd0, mk_addr(0, 12'h3C3, 2, 8'hF0),   9'd63,  1'b1, 1'b1, 0);
        send("R9",  2'd1, mk_addr(1, 12'h444, 0, 9'h1FC),  9'd9,   1'b1, 1'b0, 1);
        send("R6",  2'd3, mk_addr(3, 12'h00E, 3, 11'h000), 9'd511, 1'b0, 1'b0, 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule